// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a 256-byte serial memory that also has a second, separate 256-location register space used for protection settings. It oversamples the two bus lines with a fast system clock and recognises START and STOP conditions. It shifts in a select byte and matches its device-type field against two codes, one for the main array and one for the protection space. It also matches three chip-enable strap inputs. On a match it acknowledges, keeps an 8-bit address counter, and turns bus traffic into single-byte read and write requests on a simple synchronous memory port.

The memory itself sits outside the block, and the test environment models it as a register file. The port takes a one-cycle `mem_rd` or `mem_wr` pulse together with `mem_addr`, `mem_space` and `mem_wdata`, and returns read data on `mem_rdata` one clock after `mem_rd`. While the memory reports a self-timed program cycle on `busy_i`, the block ignores START conditions, so the part appears absent from the bus.

Top module: `eep_bus_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and begins select-byte reception. A rising SDA while SCL is high is a STOP, which releases SDA and returns the block to idle. After reset `sda_oe`, `mem_rd` and `mem_wr` are all low.
- R2: Incoming bits are taken on SCL rising edges, most significant bit first. `sda_oe` (1 = pull SDA low) only changes while SCL is low.
- R3: Select byte bits 7..4 equal to 1010 address the array and 0110 address the protection space. Bits 3..1 must equal `chip_en[2:0]`, and bit 0 = 1 requests a read. On a match the block pulls SDA low for the 9th clock.
- R4: On any select mismatch the block does not acknowledge, issues no memory request and ignores the bus until the next START.
- R5: In a write, the byte after the select byte is acknowledged and loaded into the address counter. Each following byte is acknowledged and produces one `mem_wr` pulse with the byte on `mem_wdata` at the current counter address.
- R6: A select byte with RW=1 returns the byte at the current counter address, MSB first. A write select plus address byte, followed by a repeated START and a read select, performs a random read.
- R7: During a read, a master acknowledge (SDA low on the 9th clock) continues with the next byte. A NoAck releases SDA, and the block drives nothing until the next START.
- R8: The address counter advances by one after every byte read or written, so consecutive bytes come from consecutive addresses.
- R9: The address counter wraps from FFh to 00h.
- R10: `mem_space` is 1 for transactions selected with the protection code and 0 for the array code. The two spaces hold independent contents at the same addresses.
- R11: While `busy_i` is high, START conditions are ignored and no select byte is acknowledged.
- R12: A START arriving in the middle of a byte abandons that byte without a memory request and restarts select-byte reception.
- R13: `mem_rd` and `mem_wr` are single-cycle pulses, never high together, and read data is taken from `mem_rdata` one clock after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| chip_en | input | 3 | Strap value compared with select bits 3..1 |
| busy_i | input | 1 | Memory is in a self-timed program cycle |
| mem_rd | output | 1 | One-cycle read request |
| mem_wr | output | 1 | One-cycle write request |
| mem_space | output | 1 | 0 = main array, 1 = protection space |
| mem_addr | output | 8 | Byte address for the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_rd` |

## Verification
A bad bit counter or phase flag shows up within one byte time as a missing or misplaced acknowledge, or as a shifted data byte that the master receives on the very next read. A wrong address counter produces no bus symptom until a later read returns data from the wrong location. The bench therefore reads back every write, and it continues past sequential boundaries and the FFh wrap. Errors in space or strap decoding show only as acknowledges that should be absent, or as writes landing in the other space. Those are exposed by mismatched selects followed by read-back of both spaces.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int BYTE_W = 8;
    localparam int CE_W   = 3;

    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_PROT  = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADDR,
        ST_WR,
        ST_RD
    } bus_state_e;

    // Condition and edge flags derived from the synchronised lines
    typedef struct packed {
        logic scl;
        logic scl_prev;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    // Result of matching a select byte
    typedef struct packed {
        logic hit;
        logic space;
        logic rd;
    } sel_dec_t;

    function automatic sel_dec_t decode_select(input logic [BYTE_W-1:0] b,
                                               input logic [CE_W-1:0]   ce);
        sel_dec_t d;
        logic ce_ok;
        ce_ok   = (b[3:1] == ce);
        d.space = (b[7:4] == TYPE_PROT);
        d.hit   = ce_ok && ((b[7:4] == TYPE_ARRAY) || (b[7:4] == TYPE_PROT));
        d.rd    = b[0];
        return d;
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff[0] <= scl_i;
                    sda_ff[0] <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[TOP];
    assign sda_s = sda_ff[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.scl_prev = scl_q;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s && !scl_q;
        ev.scl_fall = !scl_s && scl_q;
        ev.start    = scl_s && scl_q && sda_q && !sda_s;
        ev.stop     = scl_s && scl_q && !sda_q && sda_s;
    end

endmodule

// File: rtl/eep_byte_reg.sv
module eep_byte_reg
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load_en) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[BYTE_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end

    // R9
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && (value == '1)) |=> (value == '0));

    // R5
    ctr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (value == $past(load_val)));

endmodule

// File: rtl/eep_bus_slave.sv
module eep_bus_slave
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [CE_W-1:0]   chip_en,
    input  logic              busy_i,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_space,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    line_ev_t          ev;
    bus_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              ack_ph;
    logic              sel_rd;
    logic              rd_d1;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] ctr_q;
    sel_dec_t          dec;

    logic start_ok;
    logic rx_mode;
    logic rx_shift;
    logic byte_end;
    logic ctr_load;
    logic [2:0] tx_idx;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign start_ok = ev.start && !busy_i;
    assign rx_mode  = (state == ST_SEL) || (state == ST_ADDR) || (state == ST_WR);
    assign rx_shift = rx_mode && !ack_ph && ev.scl_rise && (cnt < LAST_BIT);
    assign byte_end = !ack_ph && ev.scl_fall && (cnt == LAST_BIT);
    assign ctr_load = (state == ST_ADDR) && byte_end && !start_ok && !ev.stop;
    assign tx_idx   = 3'(3'd7 - cnt[2:0]);
    assign dec      = decode_select(rx_q, chip_en);

    eep_byte_reg u_rx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rx_shift),
        .bit_in   (ev.sda),
        .load_en  (1'b0),
        .load_val ('0),
        .q        (rx_q)
    );

    eep_byte_reg u_tx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (1'b0),
        .bit_in   (1'b0),
        .load_en  (rd_d1),
        .load_val (mem_rdata),
        .q        (tx_q)
    );

    eep_addr_ctr #(.W(BYTE_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (rx_q),
        .inc      (mem_rd || mem_wr),
        .value    (ctr_q)
    );

    assign mem_addr  = ctr_q;
    assign mem_wdata = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ack_ph    <= 1'b0;
            sel_rd    <= 1'b0;
            sda_oe    <= 1'b0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_space <= 1'b0;
            rd_d1     <= 1'b0;
        end else begin
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
            rd_d1  <= mem_rd;
            if (start_ok) begin
                state  <= ST_SEL;
                cnt    <= '0;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_SEL, ST_ADDR, ST_WR: begin
                        if (!ack_ph) begin
                            if (rx_shift) begin
                                cnt <= cnt + 1'b1;
                            end else if (byte_end) begin
                                ack_ph <= 1'b1;
                                if (state == ST_SEL) begin
                                    if (dec.hit) begin
                                        sda_oe    <= 1'b1;
                                        mem_space <= dec.space;
                                        sel_rd    <= dec.rd;
                                        mem_rd    <= dec.rd;
                                    end else begin
                                        state  <= ST_IDLE;
                                        ack_ph <= 1'b0;
                                    end
                                end else if (state == ST_ADDR) begin
                                    sda_oe <= 1'b1;
                                end else begin
                                    sda_oe <= 1'b1;
                                    mem_wr <= 1'b1;
                                end
                            end
                        end else if (ev.scl_fall) begin
                            ack_ph <= 1'b0;
                            cnt    <= '0;
                            if (state == ST_SEL && sel_rd) begin
                                state  <= ST_RD;
                                sda_oe <= !tx_q[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                                if (state == ST_SEL) begin
                                    state <= ST_ADDR;
                                end else if (state == ST_ADDR) begin
                                    state <= ST_WR;
                                end
                            end
                        end
                    end
                    ST_RD: begin
                        if (!ack_ph) begin
                            if (ev.scl_rise && (cnt < LAST_BIT)) begin
                                cnt <= cnt + 1'b1;
                            end else if (ev.scl_fall) begin
                                if (cnt == LAST_BIT) begin
                                    sda_oe <= 1'b0;
                                    ack_ph <= 1'b1;
                                end else begin
                                    sda_oe <= !tx_q[tx_idx];
                                end
                            end
                        end else begin
                            if (ev.scl_rise) begin
                                if (ev.sda) begin
                                    state  <= ST_IDLE;
                                    ack_ph <= 1'b0;
                                end else begin
                                    mem_rd <= 1'b1;
                                end
                            end else if (ev.scl_fall) begin
                                ack_ph <= 1'b0;
                                cnt    <= '0;
                                sda_oe <= !tx_q[BYTE_W-1];
                            end
                        end
                    end
                    default: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end

    // R2
    sda_oe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && ev.scl_prev) |-> $stable(sda_oe));

    // R13
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R13
    mem_rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R13
    mem_wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    // R11
    busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && busy_i) |=> (state == ST_IDLE));

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R4
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> (!mem_wr && !mem_rd));

    // R5
    wr_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (state == ST_WR));

endmodule

// File: tb/sim_eep_bus_slave.sv
module sim_eep_bus_slave;
    localparam int Q = 6;
    localparam logic [2:0] CE = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic [2:0] chip_en = CE;
    logic       sda_oe, mem_rd, mem_wr, mem_space;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       sda_line;

    logic [7:0] arr_m  [256];
    logic [7:0] prot_m [256];
    logic [7:0] ref_a  [256];
    logic [7:0] ref_p  [256];

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int bad_pulse = 0;
    int bad_edge = 0;
    logic prev_rd = 1'b0, prev_wr = 1'b0, prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eep_bus_slave u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .chip_en   (chip_en),
        .busy_i    (busy),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_space (mem_space),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] sel_byte(input logic [3:0] t, input logic [2:0] ce,
                                            input logic rw);
        return {t, ce, rw};
    endfunction

    // memory model (environment), registered read
    always @(posedge clk) begin
        if (mem_wr) begin
            if (mem_space) prot_m[mem_addr] <= mem_wdata;
            else           arr_m[mem_addr]  <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem_space ? prot_m[mem_addr] : arr_m[mem_addr];
    end

    // R13 / R2 monitors
    always @(negedge clk) begin
        if (!rst) begin
            if ((mem_rd && mem_wr) || (mem_rd && prev_rd) || (mem_wr && prev_wr))
                bad_pulse++;
            if ((sda_oe != prev_oe) && scl) bad_edge++;
        end
        prev_rd = mem_rd;
        prev_wr = mem_wr;
        prev_oe = sda_oe;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    // write len bytes starting at a into space sp
    task automatic wr_seq(input logic sp, input logic [7:0] a, input int len,
                          input logic [7:0] d0, input logic rnd);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(sel_byte(sp ? 4'b0110 : 4'b1010, CE, 1'b0), ack);
        chk(ack, "R3 select ack", ack, 1);
        send_byte(a, ack);
        chk(ack, "R5 address ack", ack, 1);
        for (int i = 0; i < len; i++) begin
            d = rnd ? 8'($urandom) : 8'(d0 + 8'(i));
            send_byte(d, ack);
            chk(ack, "R5 data ack", ack, 1);
            if (sp) ref_p[8'(a + 8'(i))] = d;
            else    ref_a[8'(a + 8'(i))] = d;
        end
        bus_stop();
    endtask

    // random read of len bytes from a, checking each byte
    task automatic rd_seq(input logic sp, input logic [7:0] a, input int len, input string req);
        logic ack;
        logic [7:0] v, e;
        bus_start();
        send_byte(sel_byte(sp ? 4'b0110 : 4'b1010, CE, 1'b0), ack);
        send_byte(a, ack);
        bus_start();
        send_byte(sel_byte(sp ? 4'b0110 : 4'b1010, CE, 1'b1), ack);
        chk(ack, "R6 read select ack", ack, 1);
        for (int i = 0; i < len; i++) begin
            recv_byte(v, i != len - 1);
            e = sp ? ref_p[8'(a + 8'(i))] : ref_a[8'(a + 8'(i))];
            chk(v == e, req, v, e);
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        int oe_seen;
        for (int i = 0; i < 256; i++) begin
            arr_m[i] = init_val(i);
            ref_a[i] = init_val(i);
            prot_m[i] = 8'h00;
            ref_p[i] = 8'h00;
        end
        void'($urandom(32'd1234));
        tick(6);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        chk(!sda_oe && !mem_rd && !mem_wr, "R1 reset outputs", {sda_oe, mem_rd, mem_wr}, 0);
        tick(10);

        // R5 / R6 byte write then random read
        wr_seq(1'b0, 8'h10, 1, 8'hA5, 1'b0);
        rd_seq(1'b0, 8'h10, 1, "R6 random read");

        // R8 page write and sequential read
        wr_seq(1'b0, 8'h20, 4, 8'h71, 1'b0);
        rd_seq(1'b0, 8'h20, 4, "R8 sequential read");

        // R6 current-address read continues at 0x24
        bus_start();
        send_byte(sel_byte(4'b1010, CE, 1'b1), ack);
        chk(ack, "R6 current read ack", ack, 1);
        recv_byte(v, 1'b0);
        chk(v == ref_a[8'h24], "R6 current address read", v, ref_a[8'h24]);
        bus_stop();

        // R9 wrap on write and on read
        wr_seq(1'b0, 8'hFE, 3, 8'hC0, 1'b0);
        rd_seq(1'b0, 8'hFF, 3, "R9 wrap read");

        // R10 protection space separate from array
        wr_seq(1'b1, 8'h10, 1, 8'h3C, 1'b0);
        rd_seq(1'b0, 8'h10, 1, "R10 array unchanged");
        rd_seq(1'b1, 8'h10, 1, "R10 protection read");

        // R4 wrong type code and wrong strap
        bus_start();
        send_byte(sel_byte(4'b1100, CE, 1'b0), ack);
        chk(!ack, "R4 bad type nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(sel_byte(4'b1010, 3'b100, 1'b0), ack);
        chk(!ack, "R4 bad strap nack", ack, 0);
        send_byte(8'h10, ack);
        chk(!ack, "R4 ignored address", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R4 ignored data", ack, 0);
        bus_stop();
        rd_seq(1'b0, 8'h10, 1, "R4 memory untouched");

        // R7 NoAck ends read, no further driving
        bus_start();
        send_byte(sel_byte(4'b1010, CE, 1'b1), ack);
        recv_byte(v, 1'b0);
        oe_seen = 0;
        for (int i = 0; i < 9; i++) begin
            get_bit(ack);
            if (!ack) oe_seen++;
        end
        chk(oe_seen == 0, "R7 released after NoAck", oe_seen, 0);
        bus_stop();

        // R11 busy ignores START
        busy = 1'b1;
        bus_start();
        send_byte(sel_byte(4'b1010, CE, 1'b0), ack);
        chk(!ack, "R11 busy nack", ack, 0);
        send_byte(8'h22, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        busy = 1'b0;
        tick(4);
        rd_seq(1'b0, 8'h22, 1, "R11 no write while busy");

        // R12 START mid-byte aborts
        bus_start();
        send_byte(sel_byte(4'b1010, CE, 1'b0), ack);
        send_byte(8'h30, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(sel_byte(4'b1010, CE, 1'b1), ack);
        chk(ack, "R12 select after abort", ack, 1);
        recv_byte(v, 1'b0);
        chk(v == ref_a[8'h30], "R12 aborted byte not written", v, ref_a[8'h30]);
        bus_stop();

        // random traffic: R5 R8
        for (int k = 0; k < 12; k++) begin
            logic [7:0] a;
            int len;
            logic sp;
            a = 8'($urandom);
            len = 1 + int'($urandom % 4);
            sp = 1'($urandom % 2);
            wr_seq(sp, a, len, 8'h00, 1'b1);
            rd_seq(sp, a, len, "R8 random readback");
        end

        chk(bad_pulse == 0, "R13 request pulses", bad_pulse, 0);
        chk(bad_edge == 0, "R2 sda_oe edge while SCL high", bad_edge, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule